// File: doc/BRIEF.md
# Scrambled-Map 64-Source Interrupt Controller

This block gathers 64 level-sensitive interrupt lines into two 32-bit register words, word 0 ("high") and word 1 ("low"). Each word has an enable (mask) register and a pending register. A source reaches its word and bit through a fixed, non-arithmetic routing table. Pending bits are cleared by writing ones. A pending bit that is also enabled raises a single request line towards the processor.

A read-only vector word reports the winning source number in its top six bits. Software reads the vector to find which source to service. It masks and acknowledges that source, then re-enables it. A configuration word and two priority words are kept only as storage, with fixed reset values. The register port is a plain word-addressed write strobe with a combinational read path.

Top module: `intc64_map`

## Requirements
- R1: After reset, both enable words and both pending words read 0, the vector reads 0 and `irq_o` is low. The configuration word reads 0 and both priority words read 0x05309770. This assumes all sources are low during reset.
- R2: Routing table. Sources 0..15 go to word 1: source 0 to bit 0, and source n (1..15) to bit 16-n. Sources 16, 17 and 18 go to word 0 bits 2, 1 and 0. Source n (19..30) goes to word 0 bit 33-n. Source 31 also goes to word 0 bit 0, which it shares with source 18. Source n (32..47) goes to word 1 bit 63-n. Source n (48..63) goes to word 0 bit n-32. Word 0 bit 15 is never set.
- R3: Enable registers sit at offset 0 (word 0) and offset 1 (word 1). They read back the last value written. A 1 enables the bit and a 0 disables it.
- R4: Pending registers sit at offset 2 (word 0) and offset 3 (word 1). They are write-one-to-clear: written 1 bits clear on the next edge, and written 0 bits are left unchanged.
- R5: On each clock edge, every high source sets its pending bit. A clear written while the source is still high therefore has no effect.
- R6: Pending bits are recorded whatever the enable bits hold.
- R7: `irq_o` is high exactly when some pending bit is set in the same position as a set enable bit. This includes source 0, which raises `irq_o` but is never reported by the vector.
- R8: The vector word at offset 4 holds, in bits 31:26, the lowest nonzero source number whose pending and enable bits are both set. Bits 25:0 are zero. A value of 0 means no such source. If the shared word-0 bit 0 is active, the vector reports 18.
- R9: Reading the vector changes nothing, and writes to offset 4 are ignored.
- R10: The configuration word (offset 5) and the priority words (offset 6 for word 0, offset 7 for word 1) read back the last value written. Offsets 8..15 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 64 | Level interrupt sources, bit n is source n |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 4 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_o | output | 1 | Request to the processor |

## Verification
The assertions assume that every interrupt source is held low while reset is asserted. They also assume that `bus_wr` is never left unknown. Both hold for the stimulus, which keeps `irq_in` at zero through reset and drives every input at the falling edge. Random interrupt patterns are sparse, about one source in eight. Random writes go only to the eight defined offsets, so several sources compete for the vector while pending bits keep filling and clearing. Directed cases cover the out-of-range offsets, the ignored vector writes, the shared bit and clears against a held level.

// File: rtl/intc_pkg.sv
package intc_pkg;

   // Word offsets of the register port; enable and pending words are laid
   // out so that the word index adds to a base offset.
   typedef enum logic [3:0] {
      OFS_ENA_W0  = 4'd0,
      OFS_ENA_W1  = 4'd1,
      OFS_PND_W0  = 4'd2,
      OFS_PND_W1  = 4'd3,
      OFS_VECTOR  = 4'd4,
      OFS_CONFIG  = 4'd5,
      OFS_PRIO_W0 = 4'd6,
      OFS_PRIO_W1 = 4'd7
   } reg_ofs_e;

   localparam logic [31:0] PRIO_RESET = 32'h0530_9770;

   // Which register word a source lands in (0 = high word, 1 = low word).
   function automatic logic src_word(input int unsigned n);
      return (n < 16) || ((n >= 32) && (n < 48));
   endfunction

   // Which bit inside that word a source lands on.
   function automatic logic [4:0] src_bit(input int unsigned n);
      int unsigned b;
      if (n == 0)       b = 0;
      else if (n < 16)  b = 16 - n;
      else if (n < 19)  b = 18 - n;
      else if (n < 31)  b = 33 - n;
      else if (n == 31) b = 0;
      else if (n < 48)  b = 63 - n;
      else              b = n - 32;
      return 5'(b);
   endfunction

endpackage

// File: rtl/intc_src_route.sv
module intc_src_route #(
   parameter int unsigned NSRC = 64,
   parameter int unsigned DW   = 32
) (
   input  logic [NSRC-1:0]       src,
   output logic [1:0][DW-1:0]    raw
);
   import intc_pkg::*;

   always_comb begin
      raw = '0;
      for (int n = 0; n < NSRC; n++) begin
         if (src[n]) raw[src_word(n)][src_bit(n)] = 1'b1;
      end
   end

endmodule

// File: rtl/intc_bank.sv
module intc_bank #(
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] raw,
   input  logic          ena_we,
   input  logic          pnd_we,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] ena_q,
   output logic [DW-1:0] pnd_q
);

   logic [DW-1:0] clr;
   assign clr = pnd_we ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ena_q <= '0;
         pnd_q <= '0;
      end else begin
         if (ena_we) ena_q <= wdata;
         pnd_q <= (pnd_q & ~clr) | raw;
      end
   end

   // R3
   ena_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ena_we |=> (ena_q == $past(wdata)));

   // R4
   pnd_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pnd_we |=> ((pnd_q & $past(wdata & ~raw)) == '0));

   // R5
   level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (raw != '0) |=> ((pnd_q & $past(raw)) == $past(raw)));

endmodule

// File: rtl/intc_vec_enc.sv
module intc_vec_enc #(
   parameter int unsigned NSRC  = 64,
   parameter int unsigned DW    = 32,
   parameter int unsigned SRC_W = 6
) (
   input  logic [1:0][DW-1:0] act,
   output logic [SRC_W-1:0]   id
);
   import intc_pkg::*;

   // Descending scan: the last hit is the lowest nonzero source number.
   always_comb begin
      id = '0;
      for (int n = NSRC - 1; n >= 1; n--) begin
         if (act[src_word(n)][src_bit(n)]) id = SRC_W'(n);
      end
   end

endmodule

// File: rtl/intc64_map.sv
module intc64_map #(
   parameter int unsigned NSRC     = 64,
   parameter int unsigned DW       = 32,
   parameter int unsigned AW       = 4,
   parameter int unsigned SRC_W    = 6,
   parameter logic [31:0] CFG_INIT = 32'h0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] irq_in,
   input  logic            bus_wr,
   input  logic [AW-1:0]   bus_addr,
   input  logic [DW-1:0]   bus_wdata,
   output logic [DW-1:0]   bus_rdata,
   output logic            irq_o
);
   import intc_pkg::*;

   localparam int unsigned NWORD = 2;
   localparam logic [AW-1:0] A_ENA0 = AW'(OFS_ENA_W0);
   localparam logic [AW-1:0] A_ENA1 = AW'(OFS_ENA_W1);
   localparam logic [AW-1:0] A_PND0 = AW'(OFS_PND_W0);
   localparam logic [AW-1:0] A_PND1 = AW'(OFS_PND_W1);
   localparam logic [AW-1:0] A_VEC  = AW'(OFS_VECTOR);
   localparam logic [AW-1:0] A_CFG  = AW'(OFS_CONFIG);
   localparam logic [AW-1:0] A_PRI0 = AW'(OFS_PRIO_W0);
   localparam logic [AW-1:0] A_PRI1 = AW'(OFS_PRIO_W1);

   if (NSRC != NWORD * DW) begin : g_bad_nsrc
      $error("intc64_map: NSRC must equal two register words");
   end
   if (DW != 32 || NSRC != 64) begin : g_bad_map
      $error("intc64_map: routing table is fixed to 64 sources over 32-bit words");
   end
   if ((1 << SRC_W) != NSRC) begin : g_bad_srcw
      $error("intc64_map: SRC_W must encode every source number");
   end
   if (AW < 3 || DW <= SRC_W) begin : g_bad_aw
      $error("intc64_map: address or data width too small");
   end

   logic [1:0][DW-1:0] raw;
   logic [1:0][DW-1:0] ena;
   logic [1:0][DW-1:0] pnd;
   logic [1:0][DW-1:0] act;
   logic [SRC_W-1:0]   vec_id;
   logic [DW-1:0]      vec_word;
   logic [DW-1:0]      cfg_q;
   logic [DW-1:0]      pri0_q;
   logic [DW-1:0]      pri1_q;

   intc_src_route #(.NSRC(NSRC), .DW(DW)) u_route (
      .src (irq_in),
      .raw (raw)
   );

   for (genvar w = 0; w < NWORD; w++) begin : g_bank
      logic ena_we;
      logic pnd_we;
      assign ena_we = bus_wr && (bus_addr == A_ENA0 + AW'(w));
      assign pnd_we = bus_wr && (bus_addr == A_PND0 + AW'(w));

      intc_bank #(.DW(DW)) u_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .raw    (raw[w]),
         .ena_we (ena_we),
         .pnd_we (pnd_we),
         .wdata  (bus_wdata),
         .ena_q  (ena[w]),
         .pnd_q  (pnd[w])
      );
      assign act[w] = ena[w] & pnd[w];
   end

   intc_vec_enc #(.NSRC(NSRC), .DW(DW), .SRC_W(SRC_W)) u_enc (
      .act (act),
      .id  (vec_id)
   );

   assign vec_word = {vec_id, {(DW - SRC_W){1'b0}}};
   assign irq_o    = |act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= CFG_INIT;
         pri0_q <= PRIO_RESET;
         pri1_q <= PRIO_RESET;
      end else if (bus_wr) begin
         if (bus_addr == A_CFG)  cfg_q  <= bus_wdata;
         if (bus_addr == A_PRI0) pri0_q <= bus_wdata;
         if (bus_addr == A_PRI1) pri1_q <= bus_wdata;
      end
   end

   always_comb begin
      case (bus_addr)
         A_ENA0:  bus_rdata = ena[0];
         A_ENA1:  bus_rdata = ena[1];
         A_PND0:  bus_rdata = pnd[0];
         A_PND1:  bus_rdata = pnd[1];
         A_VEC:   bus_rdata = vec_word;
         A_CFG:   bus_rdata = cfg_q;
         A_PRI0:  bus_rdata = pri0_q;
         A_PRI1:  bus_rdata = pri1_q;
         default: bus_rdata = '0;
      endcase
   end

   // R7
   vec_implies_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_id != '0) |-> irq_o);

   // R8
   vec_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_o |-> (vec_id == '0));

   // R10
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == A_CFG) |=> $stable(cfg_q));

   // R10
   pri_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && (bus_addr == A_PRI0 || bus_addr == A_PRI1))
      |=> ($stable(pri0_q) && $stable(pri1_q)));

endmodule

// File: tb/intc64_map_test.sv
module intc64_map_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] irq_in = '0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   logic [31:0] m_ena [2];
   logic [31:0] m_pnd [2];
   logic [31:0] m_cfg, m_pri0, m_pri1;

   always #10 clk = ~clk;

   intc64_map uut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_o(irq_o)
   );

   function automatic int bw(int n);
      return ((n < 16) || (n >= 32 && n < 48)) ? 1 : 0;
   endfunction

   function automatic int bb(int n);
      if (n == 0)  return 0;
      if (n < 16)  return 16 - n;
      if (n < 19)  return 18 - n;
      if (n < 31)  return 33 - n;
      if (n == 31) return 0;
      if (n < 48)  return 63 - n;
      return n - 32;
   endfunction

   function automatic logic [31:0] raw_of(logic [63:0] s, int w);
      logic [31:0] r = '0;
      for (int n = 0; n < 64; n++) if (s[n] && bw(n) == w) r[bb(n)] = 1'b1;
      return r;
   endfunction

   function automatic logic [31:0] exp_vec();
      for (int n = 1; n < 64; n++)
         if (m_ena[bw(n)][bb(n)] && m_pnd[bw(n)][bb(n)]) return 32'(n) << 26;
      return 32'h0;
   endfunction

   function automatic logic exp_irq();
      return |((m_ena[0] & m_pnd[0]) | (m_ena[1] & m_pnd[1]));
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      logic [31:0] clr0, clr1, r0, r1;
      @(posedge clk);
      clr0 = '0; clr1 = '0;
      r0 = raw_of(irq_in, 0);
      r1 = raw_of(irq_in, 1);
      if (bus_wr) begin
         case (bus_addr)
            4'd0: m_ena[0] = bus_wdata;
            4'd1: m_ena[1] = bus_wdata;
            4'd2: clr0 = bus_wdata;
            4'd3: clr1 = bus_wdata;
            4'd5: m_cfg = bus_wdata;
            4'd6: m_pri0 = bus_wdata;
            4'd7: m_pri1 = bus_wdata;
            default: ;
         endcase
      end
      m_pnd[0] = (m_pnd[0] & ~clr0) | r0;
      m_pnd[1] = (m_pnd[1] & ~clr1) | r1;
      @(negedge clk);
   endtask

   task automatic wr(logic [3:0] a, logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      tick();
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [3:0] a, output logic [31:0] d);
      bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic check_all();
      logic [31:0] d;
      rd(4'd0, d); chk("R3 enable word 0", d, m_ena[0]);
      rd(4'd1, d); chk("R3 enable word 1", d, m_ena[1]);
      rd(4'd2, d); chk("R5 pending word 0", d, m_pnd[0]);
      rd(4'd3, d); chk("R5 pending word 1", d, m_pnd[1]);
      rd(4'd4, d); chk("R8 vector", d, exp_vec());
      rd(4'd5, d); chk("R10 config", d, m_cfg);
      rd(4'd6, d); chk("R10 priority word 0", d, m_pri0);
      rd(4'd7, d); chk("R10 priority word 1", d, m_pri1);
      chk("R7 irq_o", 32'(irq_o), 32'(exp_irq()));
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] d, v0;
      int srcs [12] = '{0, 1, 15, 16, 18, 19, 30, 31, 32, 47, 48, 63};
      void'($urandom(32'd20240611));
      m_ena[0] = '0; m_ena[1] = '0; m_pnd[0] = '0; m_pnd[1] = '0;
      m_cfg = '0; m_pri0 = 32'h0530_9770; m_pri1 = 32'h0530_9770;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset values
      rd(4'd0, d); chk("R1 enable word 0", d, 32'h0);
      rd(4'd1, d); chk("R1 enable word 1", d, 32'h0);
      rd(4'd2, d); chk("R1 pending word 0", d, 32'h0);
      rd(4'd3, d); chk("R1 pending word 1", d, 32'h0);
      rd(4'd4, d); chk("R1 vector", d, 32'h0);
      rd(4'd5, d); chk("R1 config", d, 32'h0);
      rd(4'd6, d); chk("R1 priority word 0", d, 32'h0530_9770);
      rd(4'd7, d); chk("R1 priority word 1", d, 32'h0530_9770);
      chk("R1 irq_o", 32'(irq_o), 32'h0);

      // R2 routing, R7 request, R4 acknowledge
      wr(4'd0, 32'hFFFF_FFFF);
      wr(4'd1, 32'hFFFF_FFFF);
      foreach (srcs[i]) begin
         int n = srcs[i];
         irq_in = 64'h1 << n;
         tick();
         irq_in = '0;
         rd(bw(n) == 0 ? 4'd2 : 4'd3, d);
         chk($sformatf("R2 source %0d own word", n), d, 32'h1 << bb(n));
         rd(bw(n) == 0 ? 4'd3 : 4'd2, d);
         chk($sformatf("R2 source %0d other word", n), d, 32'h0);
         rd(4'd4, d);
         chk($sformatf("R8 source %0d vector", n), d, exp_vec());
         chk($sformatf("R7 source %0d irq", n), 32'(irq_o), 32'h1);
         wr(4'd2, 32'hFFFF_FFFF);
         wr(4'd3, 32'hFFFF_FFFF);
         rd(4'd2, d); chk("R4 word 0 cleared", d, 32'h0);
         rd(4'd3, d); chk("R4 word 1 cleared", d, 32'h0);
      end

      // R4 writing zeros leaves bits alone
      irq_in = (64'h1 << 50) | (64'h1 << 3);
      tick();
      irq_in = '0;
      wr(4'd2, 32'h0);
      wr(4'd3, 32'h0);
      rd(4'd2, d); chk("R4 zero write keeps word 0", d, 32'h1 << 18);
      rd(4'd3, d); chk("R4 zero write keeps word 1", d, 32'h1 << 13);
      wr(4'd2, 32'h1 << 18);
      rd(4'd2, d); chk("R4 targeted clear", d, 32'h0);
      rd(4'd3, d); chk("R4 other word untouched", d, 32'h1 << 13);
      wr(4'd3, 32'hFFFF_FFFF);

      // R5 clear while level held
      irq_in = 64'h1 << 5;
      tick();
      wr(4'd3, 32'hFFFF_FFFF);
      rd(4'd3, d); chk("R5 held level survives clear", d, 32'h1 << 11);

      // R6 pending recorded while disabled
      wr(4'd1, 32'h0);
      rd(4'd3, d); chk("R6 pending while masked", d, 32'h1 << 11);
      chk("R6 irq low while masked", 32'(irq_o), 32'h0);
      rd(4'd4, d); chk("R6 vector zero while masked", d, 32'h0);
      irq_in = '0;
      wr(4'd3, 32'hFFFF_FFFF);
      wr(4'd1, 32'hFFFF_FFFF);

      // R8 lowest number wins, shared bit reports 18
      irq_in = (64'h1 << 40) | (64'h1 << 20) | (64'h1 << 63);
      tick();
      irq_in = '0;
      rd(4'd4, d); chk("R8 lowest of 20,40,63", d, 32'd20 << 26);
      wr(4'd2, 32'hFFFF_FFFF);
      wr(4'd3, 32'hFFFF_FFFF);
      irq_in = 64'h1 << 31;
      tick();
      irq_in = '0;
      rd(4'd4, d); chk("R8 shared bit reports 18", d, 32'd18 << 26);

      // R9 vector reads and writes have no effect
      rd(4'd4, v0);
      rd(4'd4, d);
      wr(4'd4, 32'hFFFF_FFFF);
      rd(4'd4, d); chk("R9 vector write ignored", d, v0);
      check_all();

      // R10 storage words and unused offsets
      wr(4'd5, 32'hA5A5_0F0F);
      wr(4'd6, 32'h1234_5678);
      wr(4'd7, 32'h9ABC_DEF0);
      for (int a = 8; a < 16; a++) begin
         wr(4'(a), 32'hFFFF_FFFF);
         rd(4'(a), d); chk($sformatf("R10 unused offset %0d", a), d, 32'h0);
      end
      check_all();

      // Random traffic
      for (int it = 0; it < 400; it++) begin
         int op = $urandom_range(0, 9);
         irq_in = {$urandom(), $urandom()} & {$urandom(), $urandom()} &
                  {$urandom(), $urandom()};
         if (op < 7) begin
            bus_wr = 1'b1;
            bus_addr = 4'($urandom_range(0, 7));
            bus_wdata = $urandom();
         end
         tick();
         bus_wr = 1'b0;
         irq_in = '0;
         check_all();
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule